// File: doc/BRIEF.md
# Bias Pin Transition Counter

This block counts how many times the panel's AC-bias output has toggled and raises a status flag once a programmed number of toggles has gone by. A bias generator elsewhere supplies a one-cycle pulse for every toggle of the bias pin. Software supplies the number of toggles to wait for, and that number loads a down-counter. Each pulse moves the counter one step toward zero. The pulse that would bring it to zero does three things: it sets the flag, it reloads the counter from the programmed value, and it freezes counting.

The counter stays frozen until software acknowledges the flag with a write-1 clear strobe. Counting then resumes with the next toggle pulse. A programmed value of zero turns the feature off: no toggle changes the counter, and the flag never sets. The counter loads from the programmed value when the controller's enable goes high. While the enable is low, toggles are ignored.

Top module: `bias_toggle_counter`

## Requirements
- R1: While reset is asserted and after reset is released, with no other stimulus, `ac_flag` is 0 and `toggles_left` is 0.
- R2: In the cycle after `ctrl_en` goes from 0 to 1, `toggles_left` equals the 8-bit `toggle_limit` that was sampled at that edge. Every value from 1 to 255 loads unchanged.
- R3: A `bias_tick` pulse decrements `toggles_left` by exactly one in the next cycle when all of these hold: `ctrl_en` is high and did not just rise, `ac_flag` is 0, `toggle_limit` is nonzero, and `toggles_left` is greater than 1.
- R4: Under the same conditions with `toggles_left` equal to 1, a `bias_tick` sets `ac_flag` to 1 in the next cycle, and `toggles_left` reloads to `toggle_limit`.
- R5: While `ac_flag` is 1, `bias_tick` pulses leave `toggles_left` unchanged.
- R6: A `flag_clr` pulse while `ac_flag` is 1 clears the flag in the next cycle. The next `bias_tick` after that resumes decrementing.
- R7: A `flag_clr` pulse in the same cycle as the `bias_tick` that reaches the terminal count leaves `ac_flag` set.
- R8: While `toggle_limit` is 0, `bias_tick` pulses leave `toggles_left` unchanged and `ac_flag` never sets.
- R9: While `ctrl_en` is 0, `bias_tick` pulses leave `toggles_left` unchanged.
- R10: A `bias_tick` while `toggles_left` is 0 and `toggle_limit` is nonzero reloads `toggles_left` from `toggle_limit` and does not set `ac_flag`.
- R11: When `ctrl_en` rises in the same cycle as a `bias_tick`, the load wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; a rising edge loads the counter |
| bias_tick | input | 1 | One-cycle pulse for each bias pin transition |
| toggle_limit | input | 8 | Programmed transition count; 0 disables the feature |
| flag_clr | input | 1 | Write-1 strobe that clears the status flag |
| ac_flag | output | 1 | Terminal-count status flag |
| toggles_left | output | 8 | Current counter value |

## Verification
Every result is registered exactly once, so each stimulus applied before a rising edge shows up on `ac_flag` and `toggles_left` one cycle later. The driver applies each input set on a falling edge and pushes the expected flag and count into a queue. The monitor pops one entry per cycle, shortly after the following rising edge, so each comparison lands on the cycle in which that result is due. Same-cycle collisions are driven as single steps so that their one-cycle outcomes are observed directly: clear with terminal count, and enable rise with tick.

// File: rtl/bias_cnt_pkg.sv
package bias_cnt_pkg;

    // Action the counter core takes in a given cycle
    typedef enum logic [2:0] {
        CNT_HOLD = 3'd0,
        CNT_LOAD = 3'd1,
        CNT_DEC  = 3'd2,
        CNT_TERM = 3'd3,
        CNT_WRAP = 3'd4
    } cnt_action_e;

endpackage

// File: rtl/bias_en_edge.sv
module bias_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic load_o
);
    typedef struct packed {
        logic en;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = en_i && !st_q.en;
endmodule

// File: rtl/bias_cnt_core.sv
module bias_cnt_core
    import bias_cnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             frozen_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_state_t;

    core_state_t st_d, st_q;
    cnt_action_e act;
    logic        limit_zero;

    always_comb begin
        limit_zero = (limit_i == '0);
        if (load_i)
            act = CNT_LOAD;
        else if (!en_i || frozen_i || limit_zero || !tick_i)
            act = CNT_HOLD;
        else if (st_q.count == '0)
            act = CNT_WRAP;
        else if (st_q.count == ONE)
            act = CNT_TERM;
        else
            act = CNT_DEC;

        st_d = st_q;
        case (act)
            CNT_LOAD, CNT_TERM, CNT_WRAP: st_d.count = limit_i;
            CNT_DEC:                      st_d.count = st_q.count - ONE;
            default:                      st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign term_o  = (act == CNT_TERM);
endmodule

// File: rtl/bias_status_flag.sv
module bias_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // setting has priority over a coincident clear
        if (set_i)
            st_d.flag = 1'b1;
        else if (clr_i)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/bias_toggle_counter.sv
module bias_toggle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             bias_tick,
    input  logic [CNT_W-1:0] toggle_limit,
    input  logic             flag_clr,
    output logic             ac_flag,
    output logic [CNT_W-1:0] toggles_left
);
    logic load;
    logic term;

    bias_en_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_en),
        .load_o (load)
    );

    bias_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .en_i     (ctrl_en),
        .tick_i   (bias_tick),
        .frozen_i (ac_flag),
        .limit_i  (toggle_limit),
        .count_o  (toggles_left),
        .term_o   (term)
    );

    bias_status_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (term),
        .clr_i  (flag_clr),
        .flag_o (ac_flag)
    );
endmodule

// File: rtl/bias_toggle_counter_chk.sv
module bias_toggle_counter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             bias_tick,
    input logic [CNT_W-1:0] toggle_limit,
    input logic             flag_clr,
    input logic             ac_flag,
    input logic [CNT_W-1:0] toggles_left,
    input logic             load,
    input logic             term
);
    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> toggles_left == $past(toggle_limit));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !load && bias_tick && !ac_flag && toggle_limit != '0 && toggles_left > CNT_W'(1))
        |=> toggles_left == CNT_W'($past(toggles_left) - CNT_W'(1)));

    // R4
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ac_flag && !(bias_tick && toggles_left == CNT_W'(1))) |=> !ac_flag);

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_flag && !load) |=> $stable(toggles_left));

    // R6
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_flag && flag_clr && !term) |=> !ac_flag);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> ac_flag);

    // R8
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ac_flag && toggle_limit == '0) |=> !ac_flag);

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> $stable(toggles_left));
endmodule

bind bias_toggle_counter bias_toggle_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_en      (ctrl_en),
    .bias_tick    (bias_tick),
    .toggle_limit (toggle_limit),
    .flag_clr     (flag_clr),
    .ac_flag      (ac_flag),
    .toggles_left (toggles_left),
    .load         (load),
    .term         (term)
);

// File: tb/bias_toggle_counter_test.sv
module bias_toggle_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct {
        logic         flag;
        logic [W-1:0] cnt;
        string        req;
    } exp_t;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         ctrl_en = 0;
    logic         bias_tick = 0;
    logic [W-1:0] toggle_limit = '0;
    logic         flag_clr = 0;
    logic         ac_flag;
    logic [W-1:0] toggles_left;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    exp_t sb[$];

    // reference state
    logic         m_flag = 0;
    logic [W-1:0] m_cnt = '0;
    logic         m_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bias_toggle_counter #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bias_tick(bias_tick),
        .toggle_limit(toggle_limit), .flag_clr(flag_clr),
        .ac_flag(ac_flag), .toggles_left(toggles_left)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed for the monitor
    task automatic step(input logic en, input logic tick, input logic [W-1:0] lim,
                        input logic clr, input string req);
        logic set;
        exp_t e;
        @(negedge clk);
        ctrl_en = en; bias_tick = tick; toggle_limit = lim; flag_clr = clr;
        set = 0;
        if (en && !m_en)
            m_cnt = lim;
        else if (en && !m_flag && lim != 0 && tick) begin
            if (m_cnt == 0) m_cnt = lim;
            else if (m_cnt == 1) begin m_cnt = lim; set = 1; end
            else m_cnt = m_cnt - 1;
        end
        if (set) m_flag = 1;
        else if (clr) m_flag = 0;
        m_en = en;
        e.flag = m_flag; e.cnt = m_cnt; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: result of each step is due one edge later
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "ac_flag", int'(ac_flag), int'(e.flag));
            check(e.req, "toggles_left", int'(toggles_left), int'(e.cnt));
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "ac_flag in reset", int'(ac_flag), 0);
        check("R1", "toggles_left in reset", int'(toggles_left), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "ac_flag after reset", int'(ac_flag), 0);
        check("R1", "toggles_left after reset", int'(toggles_left), 0);

        step(1, 0, 8'd3, 0, "R2");   // load 3
        step(1, 1, 8'd3, 0, "R3");   // 2
        step(1, 1, 8'd3, 0, "R3");   // 1
        step(1, 1, 8'd3, 0, "R4");   // flag, reload 3
        step(1, 1, 8'd3, 0, "R5");   // frozen
        step(1, 1, 8'd3, 0, "R5");
        step(1, 0, 8'd3, 1, "R6");   // clear
        step(1, 1, 8'd3, 0, "R6");   // resume -> 2
        step(1, 1, 8'd3, 0, "R3");   // 1
        step(1, 1, 8'd3, 1, "R7");   // terminal with clear -> flag stays
        step(1, 0, 8'd3, 1, "R6");   // clear
        step(0, 1, 8'd3, 0, "R9");   // disabled
        step(0, 1, 8'd3, 0, "R9");
        step(1, 1, 8'd5, 0, "R11");  // rise with tick -> load 5
        step(1, 1, 8'd5, 0, "R3");   // 4
        step(1, 1, 8'd0, 0, "R8");   // limit zero -> hold
        step(1, 1, 8'd0, 0, "R8");
        step(0, 0, 8'd0, 0, "R9");
        step(1, 0, 8'd0, 0, "R2");   // load 0
        step(1, 1, 8'd0, 0, "R8");
        step(1, 1, 8'd4, 0, "R10");  // count 0, limit 4 -> wrap to 4, no flag
        step(1, 1, 8'd4, 0, "R3");   // 3
        step(0, 0, 8'd255, 0, "R9");
        step(1, 0, 8'd255, 0, "R2"); // load 255
        step(1, 1, 8'd255, 0, "R3"); // 254
        step(0, 0, 8'd1, 0, "R9");
        step(1, 0, 8'd1, 0, "R2");   // load 1
        step(1, 1, 8'd1, 0, "R4");   // flag, reload 1
        step(1, 0, 8'd1, 1, "R6");
        step(1, 1, 8'd1, 0, "R4");   // flag again
        step(1, 0, 8'd1, 0, "R5");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule